// File: doc/BRIEF.md
# Block Header Group, Target and Predicate Decoder

This block sits behind the slot-boundary decoder of an instruction fetch path. Each block has sixteen 16-bit slots. The boundary stage has already found which slots begin an instruction (the start mask) and how many leading slots form the header. This block reads the header slots and expands their packed fields into three per-slot vectors:

- a parallel-group start bit;
- a legal-branch-destination bit;
- an execute-enable bit, which folds in predication against a 16-bit flag register.

Each header layout leaves out some bits whose value is implied. The block puts those bits back and aligns every field to the correct slot number.

A format selector picks one of four cases: no header, a one-slot grouping header, a one-slot branch-destination header, or a two-slot grouping-plus-predication header. The block also reports malformed headers. All outputs are registered, so results appear one clock after the inputs. Reset is synchronous and active high.

Top module: `hdrdec_top`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are 0 after that edge. Otherwise the outputs reflect the inputs present at the previous rising edge, with exactly one cycle of latency.
- R2: A bit of `grp_o` or `tgt_o` can be 1 only where the matching bit of `start_mask_i` is 1.
- R3: With format 0 (no header), `grp_o` and `tgt_o` both equal the start mask, and `exec_o` is all ones.
- R4: With format 1 (grouping header), the group bit of slot k, for k from 1 to 14, is bit (14-k) of `hdr0_i` ANDed with start bit k. Slots 0 and 15 get 0. `tgt_o` equals the start mask and `exec_o` is all ones.
- R5: With format 2 (branch-destination header), the destination bit of slot k, for k from 1 to 14, is bit (14-k) of `hdr0_i` ANDed with start bit k. Slots 0 and 15 get 0. `grp_o` equals the start mask and `exec_o` is all ones.
- R6: With format 3 (two-slot header), the group bit of slot 2 is implied 1 (ANDed with start bit 2). For slot k from 3 to 14, the group bit is bit (16-k) of `hdr1_i`. All other slots get 0, and `tgt_o` equals the start mask.
- R7: With format 3, the flag index is `hdr0_i[15:12]` and the sense bit is `hdr0_i[11]`.
  - The predicate bit of slot k is `hdr0_i[13-k]` for k from 3 to 13.
  - For slot 14 it is `hdr1_i[15]`, and for slot 2 it is `hdr1_i[14]`.
  - `exec_o[k]` is 0 exactly when slot k is a start slot, its predicate bit is 1, and the selected flag is 0 (sense 0) or 1 (sense 1).
- R8: `err_o` is 1 when `hdr_len_i` differs from the length that the format requires: 0 for format 0, 1 for formats 1 and 2, and 2 for format 3.
- R9: With format 1, `err_o` is 1 when `hdr0_i[13]` (the mandatory group bit of slot 1) is 0. That bit causes no error under format 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Header format: 0 none, 1 grouping, 2 branch destination, 3 grouping plus predication |
| hdr_len_i | input | 4 | Header length in slots, from the boundary decoder |
| start_mask_i | input | 16 | Bit k is 1 when slot k begins an instruction |
| flags_i | input | 16 | Condition flag register |
| hdr0_i | input | 16 | Slot 0 of the block |
| hdr1_i | input | 16 | Slot 1 of the block |
| grp_o | output | 16 | Per-slot parallel-group start |
| tgt_o | output | 16 | Per-slot legal branch destination |
| exec_o | output | 16 | Per-slot execute enable |
| err_o | output | 1 | Header malformed |

## Verification
The bench places marker bits at the two ends of each field and checks that they land on the right slots. A design off by one slot in the grouping or break mapping would move a group start onto a neighbouring slot. The implied group bit of slot 2 and the stray-position predicate bits of slots 2 and 14 are checked directly. A design that forgot to reinsert them would drop the slot-2 group start or leave a predicated slot enabled. Flag index 15, both sense values and a start mask that excludes header-marked slots are all covered, which catches an inverted sense, a truncated flag index or missing start-mask gating. Length mismatches in every format, and a cleared mandatory group bit under both one-slot layouts, separate a correct error flag from one that is tied low or raised too eagerly.

// File: rtl/hdrdec_pkg.sv
package hdrdec_pkg;
  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_PAR     = 2'd1,
    FMT_TGT     = 2'd2,
    FMT_PARPRED = 2'd3
  } hdr_fmt_e;
endpackage

// File: rtl/hdrdec_field_map.sv
// Expands packed header fields into per-slot raw bits (before start gating).
module hdrdec_field_map
  import hdrdec_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int SLOT_W = 16,
  parameter int FSEL_W = 4
) (
  input  hdr_fmt_e           fmt,
  input  logic [SLOT_W-1:0]  hdr0,
  input  logic [SLOT_W-1:0]  hdr1,
  output logic [NSLOT-1:0]   grp_raw,
  output logic [NSLOT-1:0]   tgt_raw,
  output logic [NSLOT-1:0]   pred_raw,
  output logic [FSEL_W-1:0]  fsel,
  output logic               fsense,
  output logic               lead_ok
);
  localparam int H_W      = 2 * SLOT_W;
  localparam int LAST_INS = NSLOT - 2;   // last slot usable by instructions

  logic [H_W-1:0]   hw;
  logic [NSLOT-1:0] one_bit;   // one-slot header field, slots 1..LAST_INS
  logic [NSLOT-1:0] brk_bit;   // two-slot break field with implied slot-2 bit
  logic [NSLOT-1:0] prd_bit;   // two-slot predicate field
  logic             unused_bits;

  assign hw          = {hdr0, hdr1};
  assign unused_bits = ^hw[1:0];
  assign fsel        = hw[H_W-1 -: FSEL_W];
  assign fsense      = hw[H_W-1-FSEL_W];
  assign lead_ok     = hdr0[NSLOT-3];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k >= 1 && k <= LAST_INS) begin : g_one
      assign one_bit[k] = hdr0[LAST_INS-k];
    end else begin : g_one_off
      assign one_bit[k] = 1'b0;
    end

    if (k == 2) begin : g_first
      assign brk_bit[k] = 1'b1;
      assign prd_bit[k] = hw[H_W-SLOT_W-2];
    end else if (k >= 3 && k <= LAST_INS) begin : g_rest
      assign brk_bit[k] = hw[H_W/2-k];
      assign prd_bit[k] = hw[H_W-3-k];
    end else begin : g_two_off
      assign brk_bit[k] = 1'b0;
      assign prd_bit[k] = 1'b0;
    end
  end

  always_comb begin
    grp_raw  = '1;
    tgt_raw  = '1;
    pred_raw = '0;
    unique case (fmt)
      FMT_PAR:     grp_raw = one_bit;
      FMT_TGT:     tgt_raw = one_bit;
      FMT_PARPRED: begin
        grp_raw  = brk_bit;
        pred_raw = prd_bit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hdrdec_pred_eval.sv
// Resolves predication against the selected flag.
module hdrdec_pred_eval #(
  parameter int NSLOT  = 16,
  parameter int NFLAG  = 16,
  parameter int FSEL_W = $clog2(NFLAG)
) (
  input  logic [NFLAG-1:0]  flags,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              fsense,
  input  logic [NSLOT-1:0]  pred_raw,
  input  logic [NSLOT-1:0]  start,
  output logic [NSLOT-1:0]  exec_en
);
  logic flag_bit;
  logic cond_ok;

  assign flag_bit = flags[fsel];
  assign cond_ok  = fsense ? ~flag_bit : flag_bit;
  assign exec_en  = ~(start & pred_raw & {NSLOT{~cond_ok}});
endmodule

// File: rtl/hdrdec_top.sv
module hdrdec_top
  import hdrdec_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int SLOT_W = 16,
  parameter int NFLAG  = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic [NSLOT-1:0]  start_mask_i,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic [SLOT_W-1:0] hdr0_i,
  input  logic [SLOT_W-1:0] hdr1_i,
  output logic [NSLOT-1:0]  grp_o,
  output logic [NSLOT-1:0]  tgt_o,
  output logic [NSLOT-1:0]  exec_o,
  output logic              err_o
);
  localparam int FSEL_W = $clog2(NFLAG);

  hdr_fmt_e          fmt;
  logic [NSLOT-1:0]  grp_raw, tgt_raw, pred_raw, exec_en;
  logic [FSEL_W-1:0] fsel;
  logic              fsense, lead_ok;
  logic [LEN_W-1:0]  need_len;
  logic              err_d;

  assign fmt = hdr_fmt_e'(fmt_i);

  hdrdec_field_map #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .FSEL_W(FSEL_W)) map_i (
    .fmt(fmt), .hdr0(hdr0_i), .hdr1(hdr1_i),
    .grp_raw(grp_raw), .tgt_raw(tgt_raw), .pred_raw(pred_raw),
    .fsel(fsel), .fsense(fsense), .lead_ok(lead_ok)
  );

  hdrdec_pred_eval #(.NSLOT(NSLOT), .NFLAG(NFLAG), .FSEL_W(FSEL_W)) pred_i (
    .flags(flags_i), .fsel(fsel), .fsense(fsense),
    .pred_raw(pred_raw), .start(start_mask_i), .exec_en(exec_en)
  );

  always_comb begin
    unique case (fmt)
      FMT_NONE:    need_len = LEN_W'(0);
      FMT_PARPRED: need_len = LEN_W'(2);
      default:     need_len = LEN_W'(1);
    endcase
    err_d = (hdr_len_i != need_len) || (fmt == FMT_PAR && !lead_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_o  <= '0;
      tgt_o  <= '0;
      exec_o <= '0;
      err_o  <= 1'b0;
    end else begin
      grp_o  <= grp_raw & start_mask_i;
      tgt_o  <= tgt_raw & start_mask_i;
      exec_o <= exec_en;
      err_o  <= err_d;
    end
  end

  // R2: no group or destination mark off an instruction start
  a_r2_marks_on_starts: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((grp_o | tgt_o) & ~$past(start_mask_i)) == '0));

  // R3: headerless block
  a_r3_no_header: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_i) == 2'd0) |->
      (grp_o == $past(start_mask_i) && tgt_o == $past(start_mask_i) && exec_o == '1));

  // R7: only two-slot layout may disable execution
  a_r7_exec_only_pred: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_i) != 2'd3) |-> exec_o == '1);

  // R8: one-slot layouts need length 1
  a_r8_len_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(fmt_i) == 2'd1 || $past(fmt_i) == 2'd2) &&
     $past(hdr_len_i) != LEN_W'(1)) |-> err_o);

  // R9: grouping layout needs its leading bit
  a_r9_lead_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_i) == 2'd1 && !$past(hdr0_i[NSLOT-3])) |-> err_o);
endmodule

// File: tb/hdrdec_top_tb_top.sv
module hdrdec_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_i = '0;
  logic [3:0]  hdr_len_i = '0;
  logic [15:0] start_mask_i = '0;
  logic [15:0] flags_i = '0;
  logic [15:0] hdr0_i = '0;
  logic [15:0] hdr1_i = '0;
  logic [15:0] grp_o, tgt_o, exec_o;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdrdec_top dut_i (
    .clk(clk), .rst(rst), .fmt_i(fmt_i), .hdr_len_i(hdr_len_i),
    .start_mask_i(start_mask_i), .flags_i(flags_i),
    .hdr0_i(hdr0_i), .hdr1_i(hdr1_i),
    .grp_o(grp_o), .tgt_o(tgt_o), .exec_o(exec_o), .err_o(err_o)
  );

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive at negedge, let one rising edge register, sample after it.
  task automatic apply(logic [1:0] f, logic [3:0] len, logic [15:0] st,
                       logic [15:0] fl, logic [15:0] h0, logic [15:0] h1);
    @(negedge clk);
    fmt_i = f; hdr_len_i = len; start_mask_i = st;
    flags_i = fl; hdr0_i = h0; hdr1_i = h1;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_all(string req, logic [15:0] g, logic [15:0] t,
                            logic [15:0] e, logic er);
    chk(req, "grp", grp_o, g);
    chk(req, "tgt", tgt_o, t);
    chk(req, "exec", exec_o, e);
    chk(req, "err", {15'd0, err_o}, {15'd0, er});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(2'd1, 4'd3, 16'hFFFF, 16'h0, 16'hFFFF, 16'hFFFF);
    expect_all("R1", 16'h0, 16'h0, 16'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_none;
    apply(2'd0, 4'd0, 16'h9249, 16'h0, 16'hFFFF, 16'hFFFF);
    expect_all("R3", 16'h9249, 16'h9249, 16'hFFFF, 1'b0);
  endtask

  task automatic t_par;
    // group marks at slots 1,4,12,14
    apply(2'd1, 4'd1, 16'h7FFE, 16'h0, 16'h2405, 16'h0);
    expect_all("R4", 16'h5012, 16'h7FFE, 16'hFFFF, 1'b0);
    // R2: starts only at slots 1,3
    apply(2'd1, 4'd1, 16'h000A, 16'h0, 16'h2405, 16'h0);
    chk("R2", "grp gated", grp_o, 16'h0002);
    chk("R2", "tgt gated", tgt_o, 16'h000A);
  endtask

  task automatic t_tgt;
    apply(2'd2, 4'd1, 16'h7FFE, 16'h0, 16'h2405, 16'h0);
    expect_all("R5", 16'h7FFE, 16'h5012, 16'hFFFF, 1'b0);
    // R9: cleared slot-1 bit is no error for destination layout
    apply(2'd2, 4'd1, 16'h7FFE, 16'h0, 16'h0405, 16'h0);
    expect_all("R9", 16'h7FFE, 16'h5010, 16'hFFFF, 1'b0);
  endtask

  task automatic t_parpred;
    // flag 5, sense 0, predicates at slots 2,3,7,14, breaks at 5,9
    apply(2'd3, 4'd2, 16'h7FFC, 16'h0020, 16'h5440, 16'hC880);
    expect_all("R6", 16'h0224, 16'h7FFC, 16'hFFFF, 1'b0);
    apply(2'd3, 4'd2, 16'h7FFC, 16'hFFDF, 16'h5440, 16'hC880);
    chk("R7", "exec flag clear sense0", exec_o, 16'hBF73);
    apply(2'd3, 4'd2, 16'h7FFC, 16'h0020, 16'h5C40, 16'hC880);
    chk("R7", "exec flag set sense1", exec_o, 16'hBF73);
    apply(2'd3, 4'd2, 16'h7FFC, 16'hFFDF, 16'h5C40, 16'hC880);
    chk("R7", "exec flag clear sense1", exec_o, 16'hFFFF);
    apply(2'd3, 4'd2, 16'h7FFC, 16'h8000, 16'hF440, 16'hC880);
    chk("R7", "exec flag15 set", exec_o, 16'hFFFF);
    apply(2'd3, 4'd2, 16'h7FFC, 16'h7FFF, 16'hF440, 16'hC880);
    chk("R7", "exec flag15 clear", exec_o, 16'hBF73);
    // predicated slots 3,7 not starts -> stay enabled
    apply(2'd3, 4'd2, 16'h4004, 16'hFFDF, 16'h5440, 16'hC880);
    chk("R7", "exec non-start", exec_o, 16'hBFFB);
    chk("R6", "grp gated", grp_o, 16'h0004);
  endtask

  task automatic t_errors;
    apply(2'd1, 4'd2, 16'h7FFE, 16'h0, 16'h2405, 16'h0);
    chk("R8", "par len2", {15'd0, err_o}, 16'h1);
    apply(2'd3, 4'd1, 16'h7FFC, 16'h0, 16'h5440, 16'hC880);
    chk("R8", "parpred len1", {15'd0, err_o}, 16'h1);
    apply(2'd0, 4'd1, 16'h0001, 16'h0, 16'h0, 16'h0);
    chk("R8", "none len1", {15'd0, err_o}, 16'h1);
    apply(2'd2, 4'd0, 16'h7FFE, 16'h0, 16'h2405, 16'h0);
    chk("R8", "tgt len0", {15'd0, err_o}, 16'h1);
    apply(2'd1, 4'd1, 16'h7FFE, 16'h0, 16'h0405, 16'h0);
    chk("R9", "par lead bit clear", {15'd0, err_o}, 16'h1);
    // R1: one-cycle latency, back to a clean case
    apply(2'd0, 4'd0, 16'h0003, 16'h0, 16'h0, 16'h0);
    chk("R1", "latency err", {15'd0, err_o}, 16'h0);
    chk("R1", "latency grp", grp_o, 16'h0003);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_none();
    t_par();
    t_tgt();
    t_parpred();
    t_errors();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule